// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block watches the SCL and SDA lines of a two-wire serial bus. It runs on a system clock that is much faster than the bus. It finds start and stop conditions and counts the SCL clocks of each byte. From those events it keeps three status flags: the first byte carried this node's address, this node is the transmitter, and the receiver pulled SDA low in the acknowledge slot.

The transmit flag also controls when the node may drive SDA. In slave mode, driving begins only after the acknowledge clock of the address byte. In master mode it begins when software asks for a start.

Software controls the block through four one-cycle strobes:
- **Master start:** the node is about to generate a start.
- **Arbitration lost:** the node has lost the bus to another master.
- **Communication release:** drop all status and leave the bus.
- **Wait release:** end the ninth-clock wait. When the node is transmitting, this also hands SDA back to the bus.

A module enable clears all of the status and holds it cleared while the enable is low.

Top module: `i2c_flag_tracker`

## Requirements
- R1: A start pulse (`start_o`, one cycle) is reported when synchronized SDA falls while SCL is high. A stop pulse (`stop_o`) is reported when SDA rises while SCL is high. An SDA change while SCL is low reports neither.
- R2: `bit_cnt_o` reads 0 after a start. It counts 1 to 9 on the SCL rising edges of a byte and returns to 1 on the first rising edge of the next byte.
- R3: In slave mode, `addr_hit_o` sets at the 8th SCL rising edge of the first byte after a start when the first seven bits (MSB first) equal `own_addr_i`. It never sets from a later byte or on a mismatch.
- R4: `addr_hit_o` clears on a start, a stop, a `rel_comm_i` strobe, or while `en_i` is 0.
- R5: In slave mode, an addressed node sets `xmit_o` when the 8th bit of the first byte (the direction bit) is 1, and clears it when that bit is 0. A detected start clears `xmit_o`.
- R6: A `mst_start_i` strobe sets `xmit_o`, and a start on the bus then leaves it set. A direction bit of 1 clears it, and a direction bit of 0 leaves it set.
- R7: `xmit_o` clears on a stop, a `rel_comm_i` strobe, a rising edge of `arb_lost_i`, or while `en_i` is 0.
- R8: `sda_oe_o` is 0 whenever `xmit_o` is 0. A slave in transmit first asserts it at the falling edge of the first byte's 9th clock. A master asserts it from the `mst_start_i` strobe.
- R9: A `rel_wait_i` strobe while `bit_cnt_o` is 9 and `xmit_o` is 1 clears `xmit_o` and `sda_oe_o`.
- R10: `ack_seen_o` sets when SDA is low at the 9th SCL rising edge and stays 0 when SDA is high. It clears at the first rising edge of the next byte, on a stop, on `rel_comm_i`, or while `en_i` is 0.
- R11: After reset, all flags, `sda_oe_o` and `bit_cnt_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable; 0 clears and holds all status |
| own_addr_i | input | 7 | Local slave address |
| mst_start_i | input | 1 | Strobe: node is generating a start as master |
| arb_lost_i | input | 1 | Arbitration lost indication |
| rel_comm_i | input | 1 | Strobe: release communication |
| rel_wait_i | input | 1 | Strobe: release the ninth-clock wait |
| scl_i | input | 1 | SCL line, asynchronous |
| sda_i | input | 1 | SDA line, asynchronous |
| start_o | output | 1 | Start condition pulse |
| stop_o | output | 1 | Stop condition pulse |
| bit_cnt_o | output | 4 | SCL clock number in the current byte |
| addr_hit_o | output | 1 | Address match flag |
| xmit_o | output | 1 | Transmit direction flag |
| ack_seen_o | output | 1 | Acknowledge detected flag |
| sda_oe_o | output | 1 | SDA output enable |

## Verification
The assertions assume the following about the inputs:
- Each level on SCL and SDA lasts several system clocks, so the synchronizers see every edge.
- SDA moves while SCL is high only to form a start or a stop.
- Every software strobe is exactly one cycle wide.

The stimulus keeps within these limits. It holds each line state for six system clocks, changes data only with SCL low, and pulses the strobes at falling clock edges for one cycle.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;
  localparam int unsigned CNT_W = 4;
  typedef logic [CNT_W-1:0] bit_cnt_t;
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_evt_t;
endpackage

// File: rtl/i2c_trk_sync.sv
module i2c_trk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], line_i};
  end

  assign line_o = q[STAGES-1];
endmodule

// File: rtl/i2c_trk_cond.sv
module i2c_trk_cond
  import i2c_trk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt_o.rise  = scl_i & ~scl_q;
    evt_o.fall  = ~scl_i & scl_q;
    evt_o.start = scl_i & scl_q & sda_q & ~sda_i;
    evt_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_trk_counter.sv
module i2c_trk_counter
  import i2c_trk_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  bus_evt_t          evt_i,
  input  logic              sda_i,
  output bit_cnt_t          cnt_o,
  output logic              first_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam bit_cnt_t ACK_CLK  = bit_cnt_t'(ADDR_W + 2);
  localparam bit_cnt_t ADDR_END = bit_cnt_t'(ADDR_W);

  bit_cnt_t cnt_q;
  logic     first_q;
  logic [ADDR_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      sh_q    <= '0;
    end else if (clr_i || evt_i.stop) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (evt_i.start) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      if (evt_i.rise) begin
        cnt_q <= (cnt_q == ACK_CLK) ? bit_cnt_t'(1) : cnt_q + bit_cnt_t'(1);
        if (first_q && cnt_q < ADDR_END) sh_q <= {sh_q[ADDR_W-2:0], sda_i};
      end
      if (evt_i.fall && cnt_q == ACK_CLK) first_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign first_o = first_q;
  assign addr_o  = sh_q;
endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker
  import i2c_trk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              mst_start_i,
  input  logic              arb_lost_i,
  input  logic              rel_comm_i,
  input  logic              rel_wait_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              start_o,
  output logic              stop_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              addr_hit_o,
  output logic              xmit_o,
  output logic              ack_seen_o,
  output logic              sda_oe_o
);
  localparam bit_cnt_t ADDR_END = bit_cnt_t'(ADDR_W);
  localparam bit_cnt_t RW_CLK   = bit_cnt_t'(ADDR_W + 1);
  localparam bit_cnt_t ACK_CLK  = bit_cnt_t'(ADDR_W + 2);

  logic scl_s, sda_s;
  bus_evt_t evt;
  bit_cnt_t cnt;
  logic first_byte;
  logic [ADDR_W-1:0] rx_addr;

  logic arb_q, master_q, hit_q, xmit_q, ack_q, drive_q;

  i2c_trk_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_s));
  i2c_trk_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_s));

  i2c_trk_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_s), .sda_i(sda_s), .evt_o(evt));

  i2c_trk_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(~en_i), .evt_i(evt), .sda_i(sda_s),
    .cnt_o(cnt), .first_o(first_byte), .addr_o(rx_addr));

  logic arb_rise, kill, rw_edge, ack_edge, wrap_edge, ack_fall, wait_rel;
  assign arb_rise  = arb_lost_i & ~arb_q;
  assign kill      = ~en_i | rel_comm_i | evt.stop | arb_rise;
  assign rw_edge   = evt.rise & first_byte & (cnt == ADDR_END);
  assign ack_edge  = evt.rise & (cnt == RW_CLK);
  assign wrap_edge = evt.rise & (cnt == ACK_CLK);
  assign ack_fall  = evt.fall & first_byte & (cnt == ACK_CLK);
  assign wait_rel  = rel_wait_i & xmit_q & (cnt == ACK_CLK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arb_q    <= 1'b0;
      master_q <= 1'b0;
      hit_q    <= 1'b0;
      xmit_q   <= 1'b0;
      ack_q    <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      arb_q <= arb_lost_i;

      if (kill)             master_q <= 1'b0;
      else if (mst_start_i) master_q <= 1'b1;

      if (~en_i | rel_comm_i | evt.stop | evt.start) hit_q <= 1'b0;
      else if (rw_edge && !master_q && rx_addr == own_addr_i) hit_q <= 1'b1;

      // master: direction bit 1 means read, so the node becomes receiver
      if (kill)                          xmit_q <= 1'b0;
      else if (mst_start_i)              xmit_q <= 1'b1;
      else if (evt.start && !master_q)   xmit_q <= 1'b0;
      else if (rw_edge && master_q)      xmit_q <= xmit_q & ~sda_s;
      else if (rw_edge)                  xmit_q <= sda_s & (rx_addr == own_addr_i);
      else if (wait_rel)                 xmit_q <= 1'b0;

      if (kill)             drive_q <= 1'b0;
      else if (mst_start_i) drive_q <= 1'b1;
      else if (!xmit_q)     drive_q <= 1'b0;
      else if (ack_fall)    drive_q <= 1'b1;

      if (~en_i | rel_comm_i | evt.stop) ack_q <= 1'b0;
      else if (wrap_edge)                ack_q <= 1'b0;
      else if (ack_edge)                 ack_q <= ~sda_s;
    end
  end

  assign start_o    = evt.start;
  assign stop_o     = evt.stop;
  assign bit_cnt_o  = cnt;
  assign addr_hit_o = hit_q;
  assign xmit_o     = xmit_q;
  assign ack_seen_o = ack_q;
  assign sda_oe_o   = xmit_q & drive_q;
endmodule

// File: rtl/i2c_flag_tracker_chk.sv
module i2c_flag_tracker_chk
  import i2c_trk_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           mst_start_i,
  input logic           rel_wait_i,
  input logic           start_o,
  input logic           stop_o,
  input logic [CNT_W-1:0] bit_cnt_o,
  input logic           addr_hit_o,
  input logic           xmit_o,
  input logic           ack_seen_o,
  input logic           sda_oe_o
);
  localparam bit_cnt_t RW_CLK  = bit_cnt_t'(ADDR_W + 1);
  localparam bit_cnt_t ACK_CLK = bit_cnt_t'(ADDR_W + 2);

  AST_START_STOP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o)); // R1
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_o <= ACK_CLK); // R2
  AST_HIT_AT_RW_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_hit_o) |-> bit_cnt_o == RW_CLK); // R3
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !addr_hit_o && !ack_seen_o); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !addr_hit_o && !xmit_o && !ack_seen_o); // R7
  AST_OE_NEEDS_XMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> xmit_o); // R8
  AST_WAIT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_wait_i && xmit_o && bit_cnt_o == ACK_CLK && !mst_start_i) |=> !xmit_o); // R9
  AST_ACK_AT_9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_seen_o) |-> bit_cnt_o == ACK_CLK); // R10
endmodule

bind i2c_flag_tracker i2c_flag_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mst_start_i(mst_start_i),
  .rel_wait_i(rel_wait_i), .start_o(start_o), .stop_o(stop_o),
  .bit_cnt_o(bit_cnt_o), .addr_hit_o(addr_hit_o), .xmit_o(xmit_o),
  .ack_seen_o(ack_seen_o), .sda_oe_o(sda_oe_o));

// File: tb/i2c_flag_tracker_tb.sv
module i2c_flag_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [6:0] own_addr = 7'h5A;
  logic mst_start = 1'b0, arb_lost = 1'b0, rel_comm = 1'b0, rel_wait = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic start_p, stop_p, addr_hit, xmit, ack_seen, sda_oe;
  logic [3:0] bit_cnt;
  int n_chk = 0, n_fail = 0, n_start = 0, n_stop = 0;

  always #4 clk = ~clk;

  i2c_flag_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .own_addr_i(own_addr),
    .mst_start_i(mst_start), .arb_lost_i(arb_lost), .rel_comm_i(rel_comm),
    .rel_wait_i(rel_wait), .scl_i(scl), .sda_i(sda), .start_o(start_p),
    .stop_o(stop_p), .bit_cnt_o(bit_cnt), .addr_hit_o(addr_hit), .xmit_o(xmit),
    .ack_seen_o(ack_seen), .sda_oe_o(sda_oe));

  always @(negedge clk) begin
    if (start_p) n_start++;
    if (stop_p)  n_stop++;
  end

  // {first byte[7:0], master, ack bit, exp hit, exp xmit, exp oe after 9th fall}
  localparam logic [12:0] VEC [6] = '{
    {8'hB4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hB5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'hB7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hB4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'hB5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hB4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
  endtask

  task automatic bus_stop();
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
  endtask

  // leaves SCL high after the rising edge
  task automatic put_bit(input logic b);
    lines(1'b0, b);
    lines(1'b1, b);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: mst_start = 1'b1;
      1: rel_comm  = 1'b1;
      2: rel_wait  = 1'b1;
      default: arb_lost = 1'b1;
    endcase
    @(negedge clk);
    mst_start = 1'b0;
    rel_comm  = 1'b0;
    rel_wait  = 1'b0;
    repeat (3) @(negedge clk);
    arb_lost = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int s0, p0;
    repeat (3) @(negedge clk);
    chk(addr_hit, 0, "R11 addr_hit after reset");
    chk(xmit, 0, "R11 xmit after reset");
    chk(ack_seen, 0, "R11 ack after reset");
    chk(sda_oe, 0, "R11 oe after reset");
    chk(bit_cnt, 0, "R11 bit_cnt after reset");
    rst_n = 1'b1;
    en = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [12:0] e;
      e = VEC[v];
      if (e[4]) strobe(0);
      bus_start();
      chk(bit_cnt, 0, "R2 count zero after start");
      put_byte(e[12:5]);
      chk(addr_hit, e[2], "R3 addr_hit at 8th rise");
      chk(xmit, e[1], e[4] ? "R6 master direction" : "R5 slave direction");
      put_bit(e[3]);
      chk(ack_seen, !e[3], "R10 ack at 9th rise");
      chk(sda_oe, e[4] & e[1], "R8 oe before 9th fall");
      lines(1'b0, e[3]);
      chk(sda_oe, e[0], "R8 oe after 9th fall");
      bus_stop();
      chk(xmit, 0, "R7 xmit cleared by stop");
      chk(addr_hit, 0, "R4 addr_hit cleared by stop");
      chk(ack_seen, 0, "R10 ack cleared by stop");
    end

    // counter wrap, ack clear on next byte, no re-match in second byte
    s0 = n_start;
    bus_start();
    chk(n_start - s0, 1, "R1 one start pulse");
    put_byte(8'hB4);
    put_bit(1'b0);
    chk(bit_cnt, 9, "R2 count 9 at ack clock");
    chk(ack_seen, 1, "R10 ack set");
    lines(1'b0, 1'b0);
    put_bit(1'b1);
    chk(bit_cnt, 1, "R2 wrap to 1");
    chk(ack_seen, 0, "R10 ack cleared at next byte first rise");
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    chk(addr_hit, 1, "R3 second byte does not re-evaluate");
    chk(bit_cnt, 8, "R2 count 8 in second byte");
    strobe(1);
    chk(addr_hit, 0, "R4 addr_hit cleared by rel_comm");

    // SDA toggling with SCL low is not a condition
    s0 = n_start;
    p0 = n_stop;
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    chk(n_start - s0, 0, "R1 no start while SCL low");
    chk(n_stop - p0, 0, "R1 no stop while SCL low");
    bus_stop();
    chk(n_stop - p0, 1, "R1 one stop pulse");

    // repeated start clears address match and slave direction
    bus_start();
    put_byte(8'hB5);
    put_bit(1'b0);
    lines(1'b0, 1'b0);
    chk(xmit, 1, "R5 slave read sets xmit");
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    lines(1'b1, 1'b0);
    chk(addr_hit, 0, "R4 addr_hit cleared by start");
    chk(xmit, 0, "R5 xmit cleared by start");
    chk(bit_cnt, 0, "R2 count reset by repeated start");
    lines(1'b0, 1'b0);
    bus_stop();

    // wait release during 9th clock
    bus_start();
    put_byte(8'hB5);
    put_bit(1'b0);
    lines(1'b0, 1'b0);
    chk(sda_oe, 1, "R8 slave drives after 9th fall");
    strobe(2);
    chk(xmit, 0, "R9 wait release clears xmit");
    chk(sda_oe, 0, "R9 wait release clears oe");
    bus_stop();

    // arbitration lost
    strobe(0);
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    chk(sda_oe, 1, "R8 master drives from start strobe");
    strobe(3);
    chk(xmit, 0, "R7 arb lost clears xmit");
    chk(sda_oe, 0, "R8 oe follows xmit");
    bus_stop();

    // rel_comm clears transmit
    bus_start();
    put_byte(8'hB5);
    put_bit(1'b0);
    strobe(1);
    chk(xmit, 0, "R7 rel_comm clears xmit");
    chk(ack_seen, 0, "R10 rel_comm clears ack");
    lines(1'b0, 1'b0);
    bus_stop();

    // disable
    bus_start();
    put_byte(8'hB5);
    put_bit(1'b0);
    lines(1'b0, 1'b0);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(addr_hit, 0, "R4 disable clears addr_hit");
    chk(xmit, 0, "R7 disable clears xmit");
    chk(sda_oe, 0, "R8 disable clears oe");
    en = 1'b1;
    bus_stop();

    // reset mid-transfer
    bus_start();
    put_byte(8'hB5);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(xmit, 0, "R11 reset clears xmit");
    chk(addr_hit, 0, "R11 reset clears addr_hit");
    chk(bit_cnt, 0, "R11 reset clears bit_cnt");

    finish_run();
  end
endmodule